// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master that runs IEEE Clause 45 frames to external PHY devices. Software talks to it through four 32-bit registers on a simple word-addressed register bus: a status word, a control word, a register-address word and a data word. Each frame is started by a register write, and busy flags show when the engine is free again.

An address frame starts when the address word is written. A write frame starts when the data word is written. A read frame starts when the control word is written with its read bit set. Every frame uses the PHY (port) and MMD (device) addresses last latched in the control word. The block makes the management clock from a programmable divider. It drives the data line through separate out, output-enable and in pins, so a pad cell outside the block does the tristate. During a read the block releases the line for the turnaround and data bits. If no PHY pulls the second turnaround bit low, the block flags a read error and the data word reads all ones.

Register map (word index on `reg_addr`): 0 status, 1 control, 2 address, 3 data.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, status reads 0x0000_6400 (divider field in bits [15:8] = 100, address-busy bit 0 = 0, read-error bit 1 = 0), the data word's busy bit 31 reads 0, `mdc` is low and `mdio_oe` is low.
- R2: While a frame runs, one `mdc` period is 2×(divider+1) system clocks. Outside a frame `mdc` stays low.
- R3: Writing the address word (index 2) sends 64 bits, with the first bit on the wire first: 32 ones, 00, opcode 00, port [4:0], device [4:0], turnaround 10, then bits [15:0] of the written value, MSB first. Status bit 0 reads 1 from the clock after the write until the frame ends.
- R4: Writing the data word (index 3) sends the same layout with opcode 01 and the written 16-bit value. Data-word bit 31 reads 1 until the frame ends.
- R5: Writing the control word (index 1) with bit 15 set sends opcode 11 to port bits [4:0] and device bits [12:8]. `mdio_oe` is high for bits 0 to 45 and low for bits 46 to 63. Data-word bit 31 reads 1 until the read ends.
- R6: After a read that a PHY acknowledged, data-word bits [15:0] hold the 16 bits sampled on the line, MSB first, on the rising `mdc` edges of bits 48 to 63.
- R7: If `mdio_i` is 1 at the rising `mdc` edge of bit 47, status bit 1 is set and data bits [15:0] read 0xFFFF. Each later read that ends sets or clears bit 1 from its own turnaround bit.
- R8: While either busy bit is set, writes to all four words are ignored: no new frame starts, and the divider, port, device, address and data fields keep their values.
- R9: Both busy bits read 0 exactly one system clock after the `mdc` falling edge that ends bit 63.
- R10: `mdio_o` changes only when a frame is loaded or on an `mdc` falling edge. The PHY samples it on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index: 0 status, 1 control, 2 address, 3 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed word (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data pad |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
The hardest case to reach from the ports is a register write that arrives while a frame is still in flight. It must not disturb the frame, start a second one or change any latched field. The bench starts an address frame and then, during that frame, writes new values to every word. Afterwards it checks that exactly 64 clock pulses appeared on the wire, that the captured payload is the original one and that every readable field is unchanged. A second hard case is a missing PHY. For this the bench's PHY model stays silent, so the pulled-up line shows a 1 in the turnaround. The bench checks that the error flag and the all-ones data appear, and that the next acknowledged read clears the flag.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  localparam int PRE_LEN   = 32;
  localparam int PHY_W     = 5;
  localparam int DEV_W     = 5;
  localparam int VAL_W     = 16;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + DEV_W + 2 + VAL_W;
  localparam int TA_IDX    = PRE_LEN + 4 + PHY_W + DEV_W;
  localparam int DATA_IDX  = TA_IDX + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mdio_op_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_d;
  logic             wrap;

  assign wrap     = en && (cnt_q == div);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc   <= mdc_d;
    end
  end

  // R2: clock is parked low whenever the engine is idle
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
  // R2: a rise strobe is followed by a high clock
  a_r2_rise_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_c45_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mdio_op_e         op_i,
  input  logic [PHY_W-1:0] port_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [VAL_W-1:0] payload_i,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             mdio_i,
  output logic             active,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done,
  output logic [VAL_W-1:0] rx_data,
  output logic             no_ack
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_I     = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] TA2_I    = IDX_W'(TA_IDX + 1);
  localparam logic [IDX_W-1:0] DATA_I   = IDX_W'(DATA_IDX);

  logic [FRAME_LEN-1:0] sr_q, sr_d, frame;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 act_d, done_d, ta_d;
  logic [VAL_W-1:0]     rx_d;
  mdio_op_e             op_q, op_d;

  assign frame = {{PRE_LEN{1'b1}}, 2'b00, op_i, port_i, dev_i,
                  (op_i == OP_READ) ? 2'b11 : 2'b10, payload_i};

  always_comb begin
    sr_d   = sr_q;
    idx_d  = idx_q;
    act_d  = active;
    ta_d   = no_ack;
    rx_d   = rx_data;
    op_d   = op_q;
    done_d = 1'b0;
    if (!active) begin
      if (start) begin
        sr_d  = frame;
        idx_d = '0;
        act_d = 1'b1;
        op_d  = op_i;
      end
    end else begin
      if (rise_stb && op_q == OP_READ) begin
        if (idx_q == TA2_I)        ta_d = mdio_i;
        else if (idx_q >= DATA_I)  rx_d = {rx_data[VAL_W-2:0], mdio_i};
      end
      if (fall_stb) begin
        sr_d = {sr_q[FRAME_LEN-2:0], 1'b1};
        if (idx_q == LAST_IDX) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '1;
      idx_q   <= '0;
      active  <= 1'b0;
      done    <= 1'b0;
      no_ack  <= 1'b0;
      rx_data <= '0;
      op_q    <= OP_ADDR;
    end else begin
      sr_q    <= sr_d;
      idx_q   <= idx_d;
      active  <= act_d;
      done    <= done_d;
      no_ack  <= ta_d;
      rx_data <= rx_d;
      op_q    <= op_d;
    end
  end

  assign mdio_o  = sr_q[FRAME_LEN-1];
  assign mdio_oe = active && !(op_q == OP_READ && idx_q >= TA_I);

  // R10: line data moves only on a load or a falling clock edge
  a_r10_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $past(fall_stb || (start && !active)));
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int             DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(100)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [1:0] IX_STAT = 2'd0;
  localparam logic [1:0] IX_CTRL = 2'd1;
  localparam logic [1:0] IX_ADDR = 2'd2;
  localparam logic [1:0] IX_DATA = 2'd3;
  localparam int RD_BIT  = 15;
  localparam int DEV_LSB = 8;
  localparam int DIV_LSB = 8;

  logic [DIV_W-1:0] div_q, div_d;
  logic [PHY_W-1:0] port_q, port_d;
  logic [DEV_W-1:0] dev_q, dev_d;
  logic [VAL_W-1:0] regnum_q, regnum_d, data_q, data_d;
  logic             abusy_q, abusy_d, dbusy_q, dbusy_d, err_q, err_d;
  mdio_op_e         cur_op_q, cur_op_d, start_op;
  logic             start, idle, wr_ok;
  logic [VAL_W-1:0] start_val;

  logic             eng_active, eng_done, eng_no_ack, rise_stb, fall_stb;
  logic [VAL_W-1:0] eng_rx;

  assign idle  = !abusy_q && !dbusy_q;
  assign wr_ok = reg_wr && idle;

  always_comb begin
    div_d     = div_q;
    port_d    = port_q;
    dev_d     = dev_q;
    regnum_d  = regnum_q;
    data_d    = data_q;
    abusy_d   = abusy_q;
    dbusy_d   = dbusy_q;
    err_d     = err_q;
    cur_op_d  = cur_op_q;
    start     = 1'b0;
    start_op  = OP_ADDR;
    start_val = reg_wdata[VAL_W-1:0];
    if (eng_done) begin
      abusy_d = 1'b0;
      dbusy_d = 1'b0;
      if (cur_op_q == OP_READ) begin
        err_d  = eng_no_ack;
        data_d = eng_no_ack ? '1 : eng_rx;
      end
    end else if (wr_ok) begin
      case (reg_addr)
        IX_STAT: div_d = reg_wdata[DIV_LSB +: DIV_W];
        IX_CTRL: begin
          port_d = reg_wdata[PHY_W-1:0];
          dev_d  = reg_wdata[DEV_LSB +: DEV_W];
          if (reg_wdata[RD_BIT]) begin
            start     = 1'b1;
            start_op  = OP_READ;
            start_val = '1;
            dbusy_d   = 1'b1;
          end
        end
        IX_ADDR: begin
          regnum_d = reg_wdata[VAL_W-1:0];
          start    = 1'b1;
          start_op = OP_ADDR;
          abusy_d  = 1'b1;
        end
        default: begin
          data_d   = reg_wdata[VAL_W-1:0];
          start    = 1'b1;
          start_op = OP_WRITE;
          dbusy_d  = 1'b1;
        end
      endcase
      if (start) cur_op_d = start_op;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_RESET;
      port_q   <= '0;
      dev_q    <= '0;
      regnum_q <= '0;
      data_q   <= '0;
      abusy_q  <= 1'b0;
      dbusy_q  <= 1'b0;
      err_q    <= 1'b0;
      cur_op_q <= OP_ADDR;
    end else begin
      div_q    <= div_d;
      port_q   <= port_d;
      dev_q    <= dev_d;
      regnum_q <= regnum_d;
      data_q   <= data_d;
      abusy_q  <= abusy_d;
      dbusy_q  <= dbusy_d;
      err_q    <= err_d;
      cur_op_q <= cur_op_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IX_STAT: begin
        reg_rdata[DIV_LSB +: DIV_W] = div_q;
        reg_rdata[1] = err_q;
        reg_rdata[0] = abusy_q;
      end
      IX_CTRL: begin
        reg_rdata[PHY_W-1:0]         = port_q;
        reg_rdata[DEV_LSB +: DEV_W]  = dev_q;
      end
      IX_ADDR: reg_rdata[VAL_W-1:0] = regnum_q;
      default: begin
        reg_rdata[VAL_W-1:0] = data_q;
        reg_rdata[31]        = dbusy_q;
      end
    endcase
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(eng_active), .div(div_q),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .op_i(start_op),
    .port_i(port_d), .dev_i(dev_d), .payload_i(start_val),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .active(eng_active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(eng_done), .rx_data(eng_rx), .no_ack(eng_no_ack)
  );

  // R3: a frame in flight is always covered by a busy flag
  a_r3_busy_covers_frame: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |-> (abusy_q || dbusy_q));
  // R8: writes during busy leave the latched fields alone
  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (abusy_q || dbusy_q) && !eng_done |=> $stable(div_q) && $stable(regnum_q) && $stable(port_q));
  // R9: busy flags drop the clock after the engine reports completion
  a_r9_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !abusy_q && !dbusy_q);
endmodule

// File: tb/tb_mdio_c45_master.sv
module tb_mdio_c45_master;
  logic        clk, rst_n, reg_wr, mdio_i;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  mdio_c45_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model state
  logic        arm = 1'b0, arm_seen = 1'b0;
  logic        prev_mdc = 1'b0;
  logic        phy_present = 1'b1;
  logic [15:0] phy_resp = 16'h0;
  int          rises = 0, t_r1 = 0, t_r2 = 0, fall_cyc = 0;
  logic [63:0] cap, oe_cap;

  initial mdio_i = 1'b1;

  always @(negedge clk) begin
    if (arm != arm_seen) begin
      arm_seen = arm; rises = 0; cap = '0; oe_cap = '0;
    end
    if (mdc && !prev_mdc) begin
      cap[63-rises]    = mdio_o;
      oe_cap[63-rises] = mdio_oe;
      if (rises == 0) t_r1 = cyc;
      if (rises == 1) t_r2 = cyc;
      rises = rises + 1;
    end
    if (!mdc && prev_mdc) begin
      if (rises == 64) fall_cyc = cyc;
      if (rises == 46)      mdio_i = 1'b1;
      else if (rises == 47) mdio_i = !phy_present;
      else if (rises >= 48 && rises <= 63) mdio_i = phy_present ? phy_resp[63-rises] : 1'b1;
      else mdio_i = 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // waits for both busy flags low; returns the cycle of the first idle sample
  task automatic wait_idle(output int clr);
    logic [31:0] s, dd;
    clr = -1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); #2;
      rd(2'd0, s); rd(2'd3, dd);
      if (!s[0] && !dd[31]) begin clr = cyc; break; end
    end
  endtask

  localparam int NV = 7;
  // {op[1:0], port[4:0], dev[4:0], value[15:0], present, resp[15:0]}
  localparam logic [44:0] VEC [NV] = '{
    {2'b00, 5'd3,  5'd1,  16'h1234, 1'b1, 16'h0000},
    {2'b01, 5'd3,  5'd1,  16'hBEEF, 1'b1, 16'h0000},
    {2'b11, 5'd3,  5'd1,  16'h0000, 1'b1, 16'hA5C3},
    {2'b00, 5'd31, 5'd30, 16'hFFFF, 1'b1, 16'h0000},
    {2'b11, 5'd31, 5'd30, 16'h0000, 1'b0, 16'h0000},
    {2'b11, 5'd0,  5'd0,  16'h0000, 1'b1, 16'h0000},
    {2'b01, 5'd0,  5'd0,  16'h0001, 1'b1, 16'h0000}
  };

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected done", wd);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s, d, c;
    logic [63:0] exp_f;
    int clr;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, s); check(s == 32'h0000_6400, "R1 status", s, 32'h6400);
    rd(2'd3, d); check(d[31] == 1'b0, "R1 data busy", d, 0);
    check(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);

    // R2 period at divider 100
    wr(2'd1, {16'h0, 3'b0, 5'd2, 3'b0, 5'd4});
    arm = !arm;
    wr(2'd2, 32'h0000_5555);
    wait_idle(clr);
    check(t_r2 - t_r1 == 202, "R2 period div100", t_r2 - t_r1, 202);
    check(!mdc, "R2 idle low", mdc, 0);

    wr(2'd0, 32'h0000_0200);
    rd(2'd0, s); check(s[15:8] == 8'd2, "R2 divider write", s, 32'h200);

    for (int v = 0; v < NV; v++) begin
      logic [1:0]  op;
      logic [4:0]  pt, dv;
      logic [15:0] val, resp;
      logic        pres;
      {op, pt, dv, val, pres, resp} = VEC[v];
      phy_present = pres; phy_resp = resp;
      arm = !arm;
      if (op == 2'b11) begin
        wr(2'd1, {16'h0, 1'b1, 2'b0, dv, 3'b0, pt});
        rd(2'd3, d); check(d[31], "R5 data busy on read", d, 32'h8000_0000);
      end else begin
        wr(2'd1, {16'h0, 1'b0, 2'b0, dv, 3'b0, pt});
        if (op == 2'b00) begin
          wr(2'd2, {16'h0, val});
          rd(2'd0, s); check(s[0], "R3 address busy", s, 1);
        end else begin
          wr(2'd3, {16'h0, val});
          rd(2'd3, d); check(d[31], "R4 data busy on write", d, 32'h8000_0000);
        end
      end
      wait_idle(clr);
      check(clr == fall_cyc + 1, "R9 busy clear timing", clr, fall_cyc + 1);
      check(rises == 64, "R2 64 clock pulses", rises, 64);
      check(t_r2 - t_r1 == 6, "R2 period div2", t_r2 - t_r1, 6);
      exp_f = {32'hFFFF_FFFF, 2'b00, op, pt, dv, 2'b10, val};
      if (op == 2'b11) begin
        check(cap[63:18] == exp_f[63:18], "R5 read header", cap, exp_f);
        check(oe_cap == {{46{1'b1}}, 18'h0}, "R5 output enable", oe_cap, {{46{1'b1}}, 18'h0});
        rd(2'd3, d); rd(2'd0, s);
        if (pres) begin
          check(d[15:0] == resp, "R6 read data", d, resp);
          check(!s[1], "R7 error clear", s, 0);
        end else begin
          check(d[15:0] == 16'hFFFF, "R7 all ones", d, 16'hFFFF);
          check(s[1], "R7 error flag", s, 2);
        end
      end else begin
        check(cap == exp_f, op == 2'b00 ? "R3 address frame" : "R4 write frame", cap, exp_f);
        check(&oe_cap, "R10 driven frame", oe_cap, '1);
      end
    end

    // R8 writes during a busy frame are ignored
    arm = !arm;
    wr(2'd1, {16'h0, 3'b0, 5'd6, 3'b0, 5'd5});
    wr(2'd2, 32'h0000_0F0F);
    wr(2'd2, 32'h0000_1111);
    wr(2'd3, 32'h0000_2222);
    wr(2'd1, {16'h0, 1'b1, 2'b0, 5'd1, 3'b0, 5'd9});
    wr(2'd0, 32'h0000_0700);
    wait_idle(clr);
    repeat (50) @(negedge clk);
    check(rises == 64, "R8 single frame", rises, 64);
    check(cap[15:0] == 16'h0F0F, "R8 payload kept", cap[15:0], 16'h0F0F);
    rd(2'd2, s); check(s[15:0] == 16'h0F0F, "R8 address kept", s, 16'h0F0F);
    rd(2'd3, d); check(d[15:0] == 16'h0001, "R8 data kept", d, 16'h0001);
    rd(2'd1, c); check(c == {16'h0, 3'b0, 5'd6, 3'b0, 5'd5}, "R8 control kept", c, {16'h0, 3'b0, 5'd6, 3'b0, 5'd5});
    rd(2'd0, s); check(s[15:8] == 8'd2, "R8 divider kept", s, 32'h200);
    check(!mdc && !mdio_oe, "R2 idle after frame", {mdc, mdio_oe}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule